// File: doc/BRIEF.md
# Interval Timer with Count Snapshot

This block is a down-counting interval timer that software controls over a narrow, word-addressed register bus. The timeout period is wider than the data path. Software writes it one half at a time, and the counter picks up the assembled value as soon as either half changes. Separate start and stop command bits in the control register run and halt the counter. A mode bit chooses between a single expiry and endless reloading.

Software cannot read a moving wide value safely in pieces. To get a coherent count, it writes to a snapshot register, which freezes the live counter value into a holding register. It then reads that value back one half at a time. Each expiry raises a sticky timeout flag in the status register. Any write to the status register clears the flag. An interrupt line follows the flag, gated by an enable bit.

Top module: `tmr_interval`

## Requirements
- R1: After reset, both period halves and the counter read as all ones, the timer is stopped, the timeout flag, the continuous bit and the interrupt enable are clear, and `irq` is low.
- R2: Word addresses are: status 0, control 1, period low 2, period high 3, snapshot low 4, snapshot high 5. Data is 16 bits wide. The full period is (high half << 16) | low half. A read returns its data on `bus_rdata` in the cycle after the read request.
- R3: A write to either period half loads the newly combined period into the counter and stops the timer.
- R4: Control bit 0 is the interrupt enable, bit 1 selects continuous mode, bit 2 is start and bit 3 is stop. Start and stop act only at the write and read back as 0. When both are set, stop wins.
- R5: While running, the counter decreases by one on every clock. While stopped, it holds its value.
- R6: A clock on which the running counter is at zero is a timeout. The timeout sets the flag and reloads the counter from the period. The timer keeps running in continuous mode and stops otherwise.
- R7: Status bit 0 is the timeout flag and status bit 1 reads 1 while the counter runs.
- R8: A write of any value to the status register clears the timeout flag. A timeout in the same cycle takes priority and leaves the flag set.
- R9: A write of any value to either snapshot register copies the live counter into the snapshot. Later reads of both snapshot halves return that frozen value.
- R10: `irq` is high exactly while the timeout flag and the interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 32-bit counter split into two 16-bit halves, and an interrupt taken straight from the flag with no extra register. Writing only the low period half after clearing the high half gives short periods of a few cycles. The bench can then reach one-shot expiry, continuous reload and the exact per-cycle decrement within a handful of cycles. The all-ones reset period still shows through the snapshot path. A period with a nonzero high half and a zero low half shows that the two halves are combined in the right place.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // word offsets of the fixed registers; period and snapshot halves follow
   localparam int OFF_STATUS = 0;
   localparam int OFF_CTRL   = 1;
   localparam int OFF_PER    = 2;

   // control bit positions
   localparam int CB_IEN   = 0;
   localparam int CB_CONT  = 1;
   localparam int CB_START = 2;
   localparam int CB_STOP  = 3;

   // status bit positions
   localparam int SB_FLAG = 0;
   localparam int SB_RUN  = 1;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
   import tmr_pkg::*;
#(
   parameter int AW = 3,
   parameter int NH = 2
) (
   input  logic          bus_sel,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   output logic          st_we,
   output logic          ct_we,
   output logic [NH-1:0] per_we,
   output logic          snap_we,
   output logic          rd_en
);
   localparam int SNAP_BASE = OFF_PER + NH;

   logic          wr_any;
   logic [NH-1:0] snap_hit;

   assign wr_any = bus_sel && bus_wr;
   assign rd_en  = bus_sel && !bus_wr;
   assign st_we  = wr_any && (int'(bus_addr) == OFF_STATUS);
   assign ct_we  = wr_any && (int'(bus_addr) == OFF_CTRL);

   for (genvar h = 0; h < NH; h++) begin : g_half
      assign per_we[h]   = wr_any && (int'(bus_addr) == OFF_PER + h);
      assign snap_hit[h] = wr_any && (int'(bus_addr) == SNAP_BASE + h);
   end

   assign snap_we = |snap_hit;
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
   parameter int CNT_W  = 32,
   parameter int HALF_W = 16,
   localparam int NH    = CNT_W / HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NH-1:0]     per_we,
   input  logic [HALF_W-1:0] wdata,
   input  logic              start_cmd,
   input  logic              stop_cmd,
   input  logic              cont_mode,
   input  logic              flag_clr,
   output logic [CNT_W-1:0]  count_q,
   output logic [CNT_W-1:0]  period_q,
   output logic              run_q,
   output logic              flag_q
);
   logic [CNT_W-1:0] period_nxt;
   logic             load;
   logic             tick;

   always_comb begin
      period_nxt = period_q;
      for (int h = 0; h < NH; h++) begin
         if (per_we[h]) period_nxt[h*HALF_W +: HALF_W] = wdata;
      end
   end

   assign load = |per_we;
   assign tick = run_q && (count_q == '0) && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '1;
         count_q  <= '1;
         run_q    <= 1'b0;
         flag_q   <= 1'b0;
      end else begin
         period_q <= period_nxt;

         if (load)       count_q <= period_nxt;
         else if (tick)  count_q <= period_q;
         else if (run_q) count_q <= count_q - 1'b1;

         if (load)           run_q <= 1'b0;
         else if (stop_cmd)  run_q <= 1'b0;
         else if (start_cmd) run_q <= 1'b1;
         else if (tick)      run_q <= cont_mode;

         if (tick)          flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;
      end
   end

   // R5
   dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && count_q != '0 && !load) |=> (count_q == $past(count_q) - 1'b1));

   // R5
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !load) |=> $stable(count_q));

   // R6
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && count_q == '0 && !load) |=> (flag_q && count_q == $past(period_q)));

   // R6
   oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && count_q == '0 && !load && !cont_mode && !start_cmd) |=> !run_q);

   // R3
   load_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (!run_q && count_q == period_q));

   // R8
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !(run_q && count_q == '0 && !load)) |=> !flag_q);
endmodule

// File: rtl/tmr_snap.sv
module tmr_snap #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snap_we,
   input  logic [CNT_W-1:0] count_in,
   output logic [CNT_W-1:0] snap_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       snap_q <= '0;
      else if (snap_we) snap_q <= count_in;
   end

   // R9
   snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap_we |=> (snap_q == $past(count_in)));

   // R9
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_we |=> $stable(snap_q));
endmodule

// File: rtl/tmr_interval.sv
module tmr_interval
   import tmr_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int HALF_W  = 16,
   parameter int AW      = 3,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [AW-1:0]     bus_addr,
   input  logic [HALF_W-1:0] bus_wdata,
   output logic [HALF_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int NH        = CNT_W / HALF_W;
   localparam int SNAP_BASE = OFF_PER + NH;

   initial begin
      cfg_split_chk: assert (CNT_W % HALF_W == 0 && NH >= 1)
         else $error("counter width must be a multiple of the half width");
      cfg_addr_chk: assert (SNAP_BASE + NH <= (1 << AW))
         else $error("address width too small for the register map");
      cfg_ctrl_chk: assert (HALF_W > CB_STOP)
         else $error("data width too small for control bits");
   end

   logic             st_we, ct_we, snap_we, rd_en;
   logic [NH-1:0]    per_we;
   logic [CNT_W-1:0] count_q, period_q, snap_q;
   logic             run_q, flag_q;
   logic             ien_q, cont_q;
   logic             start_cmd, stop_cmd;
   logic [HALF_W-1:0] rd_mux;

   tmr_decode #(.AW(AW), .NH(NH)) u_dec (
      .bus_sel (bus_sel),
      .bus_wr  (bus_wr),
      .bus_addr(bus_addr),
      .st_we   (st_we),
      .ct_we   (ct_we),
      .per_we  (per_we),
      .snap_we (snap_we),
      .rd_en   (rd_en)
   );

   assign start_cmd = ct_we && bus_wdata[CB_START];
   assign stop_cmd  = ct_we && bus_wdata[CB_STOP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q  <= 1'b0;
         cont_q <= 1'b0;
      end else if (ct_we) begin
         ien_q  <= bus_wdata[CB_IEN];
         cont_q <= bus_wdata[CB_CONT];
      end
   end

   tmr_core #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .per_we   (per_we),
      .wdata    (bus_wdata),
      .start_cmd(start_cmd),
      .stop_cmd (stop_cmd),
      .cont_mode(cont_q),
      .flag_clr (st_we),
      .count_q  (count_q),
      .period_q (period_q),
      .run_q    (run_q),
      .flag_q   (flag_q)
   );

   tmr_snap #(.CNT_W(CNT_W)) u_snap (
      .clk     (clk),
      .rst_n   (rst_n),
      .snap_we (snap_we),
      .count_in(count_q),
      .snap_q  (snap_q)
   );

   always_comb begin
      rd_mux = '0;
      if (int'(bus_addr) == OFF_STATUS) begin
         rd_mux[SB_FLAG] = flag_q;
         rd_mux[SB_RUN]  = run_q;
      end else if (int'(bus_addr) == OFF_CTRL) begin
         rd_mux[CB_IEN]  = ien_q;
         rd_mux[CB_CONT] = cont_q;
      end
      for (int h = 0; h < NH; h++) begin
         if (int'(bus_addr) == OFF_PER + h)   rd_mux = period_q[h*HALF_W +: HALF_W];
         if (int'(bus_addr) == SNAP_BASE + h) rd_mux = snap_q[h*HALF_W +: HALF_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (rd_en) bus_rdata <= rd_mux;
   end

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= flag_q && ien_q;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = flag_q && ien_q;
   end

   // R4
   stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_cmd |=> !run_q);

   // R10
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ien_q && !(IRQ_REG && $past(ien_q))) |-> !irq);
endmodule

// File: tb/sim_tmr_interval.sv
module sim_tmr_interval;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      logic [15:0] exp;
      string       tag;
   } item_t;
   item_t sb_q[$];

   always #(CLK_P/2) clk = ~clk;

   tmr_interval u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq)
   );

   // monitor: pops one expected item for each read seen at a clock edge
   initial begin
      forever begin
         bit pend;
         @(posedge clk);
         pend = bus_sel && !bus_wr && rst_n;
         #1;
         if (pend) begin
            item_t it;
            checks++;
            if (sb_q.size() == 0) begin
               errors++;
               $display("FAIL scoreboard: read with no expected item, got %h", bus_rdata);
            end else begin
               it = sb_q.pop_front();
               if (bus_rdata !== it.exp) begin
                  errors++;
                  $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
               end
            end
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag);
      item_t it;
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string tag);
      @(negedge clk);
      checks++;
      if (irq !== e) begin
         errors++;
         $display("FAIL %s: irq got %b expected %b", tag, irq, e);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: run did not complete, got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      idle(2);
      rst_n = 1'b1;

      // R1 reset state
      chk_irq(1'b0, "R1 irq after reset");
      rd(3'd0, 16'h0000, "R1 status after reset");
      rd(3'd1, 16'h0000, "R1 control after reset");
      rd(3'd2, 16'hFFFF, "R1 period low after reset");
      rd(3'd3, 16'hFFFF, "R1 period high after reset");
      wr(3'd4, 16'h0000);
      rd(3'd4, 16'hFFFF, "R1 counter low all ones");
      rd(3'd5, 16'hFFFF, "R1 counter high all ones");

      // R2 halves combine; R3 period write loads counter
      wr(3'd3, 16'h0001);
      wr(3'd2, 16'h0000);
      wr(3'd5, 16'h1234);
      rd(3'd5, 16'h0001, "R2 snapshot high of combined period");
      rd(3'd4, 16'h0000, "R2 snapshot low of combined period");

      // period of 5
      wr(3'd3, 16'h0000);
      wr(3'd2, 16'h0005);
      rd(3'd2, 16'h0005, "R2 period low readback");

      // R5 exact decrement: start, one idle cycle, snapshot sees 4
      wr(3'd1, 16'h0005);
      wr(3'd4, 16'h0000);
      rd(3'd4, 16'h0004, "R5 count after one decrement");
      rd(3'd0, 16'h0002, "R7 running status bit");

      // R6 one-shot expiry
      idle(10);
      rd(3'd0, 16'h0001, "R6 one-shot flag set and stopped");
      chk_irq(1'b1, "R10 irq with enable and flag");
      wr(3'd4, 16'h0000);
      rd(3'd4, 16'h0005, "R6 counter reloaded from period");

      // R8 clear on status write
      wr(3'd0, 16'h0000);
      chk_irq(1'b0, "R10 irq drops after clear");
      rd(3'd0, 16'h0000, "R8 flag cleared");

      // R6 continuous mode, interrupt disabled
      wr(3'd1, 16'h0006);
      idle(20);
      rd(3'd0, 16'h0003, "R6 continuous keeps running with flag");
      chk_irq(1'b0, "R10 irq masked by enable");

      // R4 stop wins over start, strobes read as zero
      wr(3'd1, 16'h000E);
      rd(3'd0, 16'h0001, "R4 stop wins, timer stopped");
      rd(3'd1, 16'h0002, "R4 control readback without strobes");

      // R3/R5 period write while running stops; stopped counter holds
      wr(3'd1, 16'h0006);
      wr(3'd2, 16'h0009);
      rd(3'd0, 16'h0001, "R3 period write stops timer");
      idle(5);
      wr(3'd5, 16'h0000);
      rd(3'd4, 16'h0009, "R9 snapshot via high register, R5 held value");
      idle(3);
      rd(3'd4, 16'h0009, "R9 snapshot stays frozen");

      idle(3);
      checks++;
      if (sb_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: %0d items left expected 0", sb_q.size());
      end
      if (!done) begin
         done = 1;
         finish_run();
      end
   end
endmodule